// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Block

This block puts a simple serial port on a processor bus. Four word-spaced registers sit in a 16-byte window: receive data, transmit data, status and control. Incoming bytes arrive on a valid/ready byte stream and wait in an eight-entry receive queue. The processor drains the queue by reading the receive register. Each write to the transmit register sends one byte out on an output byte stream. Baud timing and bit-level framing belong to the stages that drive and consume these streams, and they are not part of this block.

The status word is built live from the queue occupancy and from a sticky pending flag. The pending flag is raised in three cases: a byte is waiting, a transmit write happens, or the flag is already set. A status read lowers it again, but only when the queue is empty once that cycle ends. A level interrupt output follows the pending flag, gated by an enable bit in the control register. A control write with the flush bit set empties the receive queue.

The bus uses a one-cycle strobe. Read data is presented combinationally during the strobe cycle, and every state change takes effect at the clock edge that ends that cycle.

Top module: `uart_regif`

## Requirements
- R1: The register is selected by address bits [3:2]: 0 is receive, 1 is transmit, 2 is status and 3 is control. Address bits [1:0] are ignored. Any address with a bit above bit 3 set is outside the map: a read from it returns 0 and a write to it changes nothing.
- R2: After reset the control and transmit registers are 0, the queue is empty, `irq` and `tx_valid` are low, `rx_ready` is high, and a status read returns 0x04.
- R3: Reading the receive register returns the oldest queued byte in bits [7:0], with zeros above. If the queue is not empty, the read also removes that byte, so bytes leave in arrival order.
- R4: Reading the receive register while the queue is empty returns the byte stored in the slot the next arrival will fill, and the queue stays empty.
- R5: Status bits are: bit0 set when at least one byte is queued, bit1 set when eight bytes are queued, bit2 always 1, bit4 the pending flag. Bits 3, 5, 6, 7 and bits 31:8 always read 0.
- R6: `rx_ready` is low while eight bytes are queued. A byte offered in that state is not stored.
- R7: A control write stores the whole word, and a control read returns it. If bit1 of the written word is set, the queue occupancy and the write slot both return to 0. During that write cycle `rx_ready` is low, so no arriving byte is accepted.
- R8: A transmit write stores the whole word and sets the pending flag. In the next cycle `tx_valid` is high for exactly one cycle, with `tx_data` equal to bits [7:0] of the written word. A transmit read returns the stored word.
- R9: The pending flag is set in two cases: when the queue holds a byte at the end of a cycle, and on a transmit write. A status read returns the flag value from before the read, then clears the flag unless the queue is non-empty at the end of that cycle.
- R10: `irq` is high exactly when the pending flag and control bit4 are both set.
- R11: A write to the status register changes no state.
- R12: A receive read and an accepted arriving byte in the same cycle leave the occupancy unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid during the strobe cycle; 0 otherwise |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block accepts the incoming byte this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle. First, a status read can coincide with a byte being accepted. The read has to report the pending flag as it stood before the read, and the flag has to stay set because the queue is non-empty at the end of that cycle. Second, a flush write can coincide with an offered byte. The bench presents the byte during the flush cycle and checks two things: `rx_ready` is low in that cycle, and the following status read shows an empty queue. A receive read paired with an arriving byte is also applied. The bench judges it by the order of the bytes that are read back.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    // word index decoded from address bits [3:2]
    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_idx_e;

    // status bit positions
    localparam int ST_RX_AVAIL = 0;
    localparam int ST_RX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_TX_FULL  = 3;
    localparam int ST_PENDING  = 4;

    // control bit positions
    localparam int CT_TX_CLR   = 0;
    localparam int CT_RX_FLUSH = 1;
    localparam int CT_IRQ_EN   = 4;

    // one decoded access per cycle
    typedef struct packed {
        logic rd_rxd;
        logic rd_txd;
        logic wr_txd;
        logic rd_stat;
        logic rd_ctrl;
        logic wr_ctrl;
    } access_t;

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output access_t           acc_o
);

    logic     in_map;
    reg_idx_e idx;

    assign idx = reg_idx_e'(addr_i[3:2]);

    // anything above the 16-byte window falls outside the map
    generate
        if (ADDR_W > 4) begin : g_upper
            assign in_map = (addr_i[ADDR_W-1:4] == '0);
        end else begin : g_exact
            assign in_map = 1'b1;
        end
    endgenerate

    always_comb begin
        acc_o = '0;
        if (en_i && in_map) begin
            unique case (idx)
                REG_RXD:  acc_o.rd_rxd  = !we_i;
                REG_TXD:  begin
                    acc_o.wr_txd = we_i;
                    acc_o.rd_txd = !we_i;
                end
                REG_STAT: acc_o.rd_stat = !we_i;
                REG_CTRL: begin
                    acc_o.wr_ctrl = we_i;
                    acc_o.rd_ctrl = !we_i;
                end
                default:  acc_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter  int DEPTH = 8,              // power of two
    parameter  int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    data_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             full_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t      st_d, st_q;
    logic             do_push, do_pop;
    logic [PTR_W-1:0] rptr;
    logic [DW-1:0]    slot_q [DEPTH];

    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && (st_q.cnt != '0) && !flush_i;
    // read slot trails the write slot by the occupancy, wrapping
    assign rptr    = st_q.wptr - st_q.cnt[PTR_W-1:0];

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wptr = st_q.wptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[i] <= '0;
                end else if (do_push && (st_q.wptr == PTR_W'(i))) begin
                    slot_q[i] <= data_i;
                end
            end
        end
    endgenerate

    assign head_o     = slot_q[rptr];
    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] txw;
        logic              txv;
        logic              pend;
    } regs_t;

    regs_t              st_d, st_q;
    access_t            acc;
    logic               flush_now;
    logic               rx_push;
    logic [BYTE_W-1:0]  rx_head;
    logic [CNT_W-1:0]   rx_cnt_q;
    logic [CNT_W-1:0]   rx_cnt_next;
    logic               rx_full;
    logic [DATA_W-1:0]  stat_word;
    logic               pend_flag;
    logic [DATA_W-1:0]  ctrl_word;
    logic               unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[1:0];

    uart_reg_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .en_i   (bus_en),
        .we_i   (bus_we),
        .addr_i (bus_addr),
        .acc_o  (acc)
    );

    assign flush_now = acc.wr_ctrl && bus_wdata[CT_RX_FLUSH];
    assign rx_ready  = !rx_full && !flush_now;
    assign rx_push   = rx_valid && rx_ready;

    uart_rx_fifo #(
        .DEPTH (DEPTH),
        .DW    (BYTE_W)
    ) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_push),
        .data_i     (rx_data),
        .pop_i      (acc.rd_rxd),
        .flush_i    (flush_now),
        .head_o     (rx_head),
        .cnt_o      (rx_cnt_q),
        .cnt_next_o (rx_cnt_next),
        .full_o     (rx_full)
    );

    // next-state logic
    always_comb begin
        st_d     = st_q;
        st_d.txv = 1'b0;
        if (acc.wr_txd) begin
            st_d.txw = bus_wdata;
            st_d.txv = 1'b1;
        end
        if (acc.wr_ctrl) begin
            st_d.ctrl = bus_wdata;
        end
        if (acc.rd_stat) begin
            st_d.pend = 1'b0;
        end
        if (acc.wr_txd || (rx_cnt_next != '0)) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_flag = st_q.pend;
    assign ctrl_word = st_q.ctrl;

    always_comb begin
        stat_word              = '0;
        stat_word[ST_RX_AVAIL] = (rx_cnt_q != '0);
        stat_word[ST_RX_FULL]  = rx_full;
        stat_word[ST_TX_EMPTY] = 1'b1;
        stat_word[ST_TX_FULL]  = 1'b0;
        stat_word[ST_PENDING]  = pend_flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (acc.rd_rxd)  bus_rdata = DATA_W'(rx_head);
        if (acc.rd_txd)  bus_rdata = st_q.txw;
        if (acc.rd_stat) bus_rdata = stat_word;
        if (acc.rd_ctrl) bus_rdata = ctrl_word;
    end

    assign tx_valid = st_q.txv;
    assign tx_data  = st_q.txw[BYTE_W-1:0];
    assign irq      = pend_flag && ctrl_word[CT_IRQ_EN];

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
    parameter  int ADDR_W = 8,
    parameter  int DEPTH  = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wbyte,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              pend,
    input logic [7:0]        ctrl_lo
);

    logic [ADDR_W-1:0] widx;
    logic              wr_tx, wr_st, wr_ct, rd_st;

    assign widx  = bus_addr >> 2;
    assign wr_tx = bus_en && bus_we && (widx == ADDR_W'(1));
    assign wr_st = bus_en && bus_we && (widx == ADDR_W'(2));
    assign rd_st = bus_en && !bus_we && (widx == ADDR_W'(2));
    assign wr_ct = bus_en && bus_we && (widx == ADDR_W'(3));

    // R3: occupancy never exceeds the queue depth
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R6: a full queue refuses input
    a_r6_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

    // R7: flush empties the queue and blocks input in its own cycle
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ct && wbyte[1]) |=> (fifo_cnt == '0));
    a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ct && wbyte[1]) |-> !rx_ready);

    // R8: transmit write gives one pulse with the low byte and raises pending
    a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (tx_valid && (tx_data == $past(wbyte))));
    a_r8_tx_pend: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> pend);
    a_r8_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx |=> !tx_valid);

    // R9: status read with nothing queued or arriving clears pending
    a_r9_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && (fifo_cnt == '0) && !(rx_valid && rx_ready)) |=> !pend);

    // R10: interrupt enable cleared forces irq low
    a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ct && !wbyte[4]) |=> !irq);

    // R11: status write leaves control untouched
    a_r11_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_st |=> $stable(ctrl_lo));

endmodule

bind uart_regif uart_regif_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wbyte    (bus_wdata[7:0]),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .irq      (irq),
    .fifo_cnt (rx_cnt_q),
    .pend     (pend_flag),
    .ctrl_lo  (ctrl_word[7:0])
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 21;

    typedef struct packed {
        logic        en;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        rxv;
        logic [7:0]  rxd;
        logic        chk;
        logic [31:0] exp;
        logic        rdy;
        logic [3:0]  req;
    } vec_t;

    // addresses: 0x00 receive, 0x04 transmit, 0x08 status, 0x0C control
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h04, 1'b1,4'd5},  // R5 idle status
        '{1'b0,1'b0,8'h00,32'h0,  1'b1,8'h11,1'b0,32'h0,  1'b1,4'd3},  // R3 push
        '{1'b1,1'b0,8'h08,32'h0,  1'b1,8'h22,1'b1,32'h15, 1'b1,4'd9},  // R9 read with arrival
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h15, 1'b1,4'd9},  // R9 flag held
        '{1'b1,1'b0,8'h00,32'h0,  1'b0,8'h00,1'b1,32'h11, 1'b1,4'd3},  // R3 oldest
        '{1'b1,1'b0,8'h00,32'h0,  1'b1,8'h33,1'b1,32'h22, 1'b1,4'd12}, // R12 pop+push
        '{1'b1,1'b0,8'h00,32'h0,  1'b0,8'h00,1'b1,32'h33, 1'b1,4'd12}, // R12 order
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h14, 1'b1,4'd9},  // R9 empty, flag set
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h04, 1'b1,4'd9},  // R9 cleared
        '{1'b1,1'b0,8'h00,32'h0,  1'b0,8'h00,1'b1,32'h00, 1'b1,4'd4},  // R4 empty read
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h04, 1'b1,4'd4},  // R4 still empty
        '{1'b1,1'b1,8'h04,32'h1A5,1'b0,8'h00,1'b0,32'h0,  1'b1,4'd8},  // R8 tx write
        '{1'b1,1'b0,8'h04,32'h0,  1'b0,8'h00,1'b1,32'h1A5,1'b1,4'd8},  // R8 readback
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h14, 1'b1,4'd8},  // R8 pending
        '{1'b1,1'b0,8'h10,32'h0,  1'b0,8'h00,1'b1,32'h00, 1'b1,4'd1},  // R1 outside map
        '{1'b1,1'b1,8'h14,32'hFF, 1'b0,8'h00,1'b0,32'h0,  1'b1,4'd1},  // R1 write outside
        '{1'b1,1'b0,8'h0C,32'h0,  1'b0,8'h00,1'b1,32'h00, 1'b1,4'd1},  // R1 ctrl untouched
        '{1'b1,1'b1,8'h08,32'hFF, 1'b0,8'h00,1'b0,32'h0,  1'b1,4'd11}, // R11 status write
        '{1'b1,1'b0,8'h08,32'h0,  1'b0,8'h00,1'b1,32'h04, 1'b1,4'd11}, // R11 status same
        '{1'b1,1'b0,8'h0C,32'h0,  1'b0,8'h00,1'b1,32'h00, 1'b1,4'd11}, // R11 ctrl same
        '{1'b1,1'b0,8'h0B,32'h0,  1'b0,8'h00,1'b1,32'h04, 1'b1,4'd1}   // R1 low bits ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regif u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, settle, return before the rising edge
    task automatic bus(input logic en, input logic we, input logic [7:0] addr,
                       input logic [31:0] wd, input logic rv, input logic [7:0] rd);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        #1;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        idle();
        chk(2, {31'b0, irq}, 32'h0, "R2 irq after reset");
        chk(2, {31'b0, tx_valid}, 32'h0, "R2 tx_valid after reset");
        chk(2, {31'b0, rx_ready}, 32'h1, "R2 rx_ready after reset");
        bus(1'b1, 1'b0, 8'h08, 32'h0, 1'b0, 8'h00);
        chk(2, bus_rdata, 32'h04, "R2 status after reset");

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus(VECS[i].en, VECS[i].we, VECS[i].addr, VECS[i].wdata,
                VECS[i].rxv, VECS[i].rxd);
            if (VECS[i].chk)
                chk(int'(VECS[i].req), bus_rdata, VECS[i].exp, $sformatf("vector %0d rdata", i));
            chk(int'(VECS[i].req), {31'b0, rx_ready}, {31'b0, VECS[i].rdy},
                $sformatf("vector %0d rx_ready", i));
        end

        // R8: transmit pulse
        bus(1'b1, 1'b1, 8'h04, 32'hCAFE_005A, 1'b0, 8'h00);
        idle();
        chk(8, {31'b0, tx_valid}, 32'h1, "R8 tx_valid pulse");
        chk(8, {24'b0, tx_data}, 32'h5A, "R8 tx_data");
        idle();
        chk(8, {31'b0, tx_valid}, 32'h0, "R8 tx_valid single cycle");

        // R6: fill to eight, offer one more
        for (int i = 0; i < 8; i++) bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'(8'h40 + i));
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'hEE);
        chk(6, {31'b0, rx_ready}, 32'h0, "R6 ready low when full");
        bus(1'b1, 1'b0, 8'h08, 32'h0, 1'b0, 8'h00);
        chk(5, bus_rdata, 32'h17, "R5 full status");
        for (int i = 0; i < 8; i++) begin
            bus(1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
            chk(3, bus_rdata, 32'(8'h40 + i), "R3/R6 drain order, no extra byte");
        end
        bus(1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
        chk(4, bus_rdata, 32'h40, "R4 stale read after wrap");

        // R10: interrupt gating
        bus(1'b1, 1'b1, 8'h0C, 32'h10, 1'b0, 8'h00);
        idle();
        chk(10, {31'b0, irq}, 32'h1, "R10 irq with enable");
        bus(1'b1, 1'b0, 8'h08, 32'h0, 1'b0, 8'h00);
        chk(9, bus_rdata, 32'h14, "R9 status before clear");
        idle();
        chk(10, {31'b0, irq}, 32'h0, "R10 irq after clear");
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'hC3);
        idle();
        chk(10, {31'b0, irq}, 32'h1, "R10 irq from arrival");
        bus(1'b1, 1'b1, 8'h0C, 32'h0, 1'b0, 8'h00);
        idle();
        chk(10, {31'b0, irq}, 32'h0, "R10 irq disabled");

        // R7: flush with a colliding arrival
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'hD1);
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'hD2);
        bus(1'b1, 1'b1, 8'h0C, 32'h2, 1'b1, 8'h99);
        chk(7, {31'b0, rx_ready}, 32'h0, "R7 ready low during flush");
        bus(1'b1, 1'b0, 8'h08, 32'h0, 1'b0, 8'h00);
        chk(7, bus_rdata, 32'h14, "R7 queue empty after flush");
        bus(1'b1, 1'b0, 8'h0C, 32'h0, 1'b0, 8'h00);
        chk(7, bus_rdata, 32'h2, "R7 control readback");
        bus(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'h77);
        bus(1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
        chk(7, bus_rdata, 32'h77, "R7 first byte after flush");
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule